// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Shift Register

This block is a parallel-in / serial-in, serial-out shift register of eight stages (the width is a parameter). One free-running system clock drives every stage. A synchronous active-high inhibit input freezes the register at any edge where it is high. This inhibit input plays the part of a second, OR-combined clock input that stops clocking while it is held high.

A mode select picks between two operations. Low loads all parallel inputs into the stages on the next unfrozen edge. High chains the stages so that the serial input enters the first stage and each value moves one stage toward the output. The serial output is the value of the last stage.

An active-low clear acts at once and without a clock, and overrides every other input. Its release passes through a short synchronizer, so no stage leaves clear on a partial edge.

Top module: `gated_piso_shreg`

## Requirements
- R1: While rst_ni is low, every stage and ser_o are 0 at once, without waiting for a clock edge, whatever the other inputs and the clock do. This holds even when the clear arrives in the middle of a shift sequence.
- R2: After rst_ni rises, the first two rising clock edges leave every stage at 0. The third edge is the first that can load or shift.
- R3: At a rising edge with inhibit_i = 1, every stage keeps its value, whatever shift_nload_i, ser_i and par_i are.
- R4: At a rising edge with inhibit_i = 0 and shift_nload_i = 0, stage k takes par_i[k] for every k. Stage 0 is the first stage and stage 7 is the last. Nothing changes before that edge, and back-to-back loads each replace the whole contents.
- R5: During a load (shift_nload_i = 0), ser_i has no effect on any stage.
- R6: At a rising edge with inhibit_i = 0 and shift_nload_i = 1, stage 0 takes ser_i and stage k takes the old value of stage k-1.
- R7: ser_o is the value of stage 7. After a load, par_i[7] appears first, then par_i[6] and so on, one bit per shift. A bit entering at ser_i reaches ser_o after eight shifts.
- R8: inhibit_i goes from 0 to 1 only while the clock is high.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low clear, release synchronized |
| inhibit_i | input | 1 | Synchronous clock inhibit, 1 = hold all stages |
| shift_nload_i | input | 1 | 1 = shift, 0 = parallel load |
| ser_i | input | 1 | Serial data into stage 0 |
| par_i | input | WIDTH | Parallel data, bit k to stage k |
| ser_o | output | 1 | Serial output, value of the last stage |

## Verification
The bound checker compares the stage vector with its value one edge earlier on every cycle. It confirms that inhibited edges hold, that loads copy the parallel word with the serial input ignored, and that shifts move every stage one place. It also confirms that the stages stay zero while clear or its synchronizer is active.

Other behaviours are visible only through the bench's scenarios:
- the immediate response to a clear in the middle of a shift;
- the exact count of dead edges after release;
- the bit order as it emerges at ser_o;
- the timing rule for raising inhibit.

The bench compares every output bit against its own model of the register.

// File: rtl/piso_pkg.sv
package piso_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } op_e;
endpackage

// File: rtl/piso_rst_sync.sv
module piso_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  // assert asynchronously, release after STAGES edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/piso_ctrl.sv
module piso_ctrl
  import piso_pkg::*;
(
  input  logic inhibit_i,
  input  logic shift_nload_i,
  output op_e  op_o
);
  always_comb begin
    if (inhibit_i)          op_o = OP_HOLD;
    else if (shift_nload_i) op_o = OP_SHIFT;
    else                    op_o = OP_LOAD;
  end
endmodule

// File: rtl/piso_stage.sv
module piso_stage
  import piso_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  op_e  op_i,
  input  logic shift_d_i,
  input  logic load_d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= 1'b0;
    end else begin
      unique case (op_i)
        OP_LOAD:  q_o <= load_d_i;
        OP_SHIFT: q_o <= shift_d_i;
        default:  q_o <= q_o;
      endcase
    end
  end
endmodule

// File: rtl/gated_piso_shreg.sv
module gated_piso_shreg
  import piso_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inhibit_i,
  input  logic             shift_nload_i,
  input  logic             ser_i,
  input  logic [WIDTH-1:0] par_i,
  output logic             ser_o
);
  localparam int unsigned LAST = WIDTH - 1;

  logic             rst_sync_n;
  op_e              op;
  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] shift_d;

  piso_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  piso_ctrl u_ctrl (
    .inhibit_i     (inhibit_i),
    .shift_nload_i (shift_nload_i),
    .op_o          (op)
  );

  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign shift_d[k] = ser_i;
    end else begin : g_body
      assign shift_d[k] = stage_q[k-1];
    end

    piso_stage u_stage (
      .clk_i     (clk_i),
      .rst_ni    (rst_sync_n),
      .op_i      (op),
      .shift_d_i (shift_d[k]),
      .load_d_i  (par_i[k]),
      .q_o       (stage_q[k])
    );
  end

  assign ser_o = stage_q[LAST];
endmodule

// File: rtl/gated_piso_shreg_chk.sv
module gated_piso_shreg_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rst_sync_n,
  input logic             inhibit_i,
  input logic             shift_nload_i,
  input logic             ser_i,
  input logic [WIDTH-1:0] par_i,
  input logic [WIDTH-1:0] stage_q,
  input logic             ser_o
);
  AST_CLEAR_OUT_ZERO: assert property (@(posedge clk_i)
    !rst_ni |-> (ser_o == 1'b0)); // R1

  AST_SYNC_HOLDS_ZERO: assert property (@(posedge clk_i)
    !rst_sync_n |-> (stage_q == '0)); // R2

  AST_INHIBIT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (rst_sync_n && inhibit_i) |=> $stable(stage_q)); // R3

  AST_LOAD_CAPTURES: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (rst_sync_n && !inhibit_i && !shift_nload_i) |=> (stage_q == $past(par_i))); // R4

  AST_SHIFT_MOVES: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (rst_sync_n && !inhibit_i && shift_nload_i)
      |=> (stage_q == {$past(stage_q[WIDTH-2:0]), $past(ser_i)})); // R6

  AST_SEROUT_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (rst_sync_n && !inhibit_i && shift_nload_i)
      |=> (ser_o == $past(stage_q[WIDTH-2]))); // R7
endmodule

bind gated_piso_shreg gated_piso_shreg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rst_sync_n    (rst_sync_n),
  .inhibit_i     (inhibit_i),
  .shift_nload_i (shift_nload_i),
  .ser_i         (ser_i),
  .par_i         (par_i),
  .stage_q       (stage_q),
  .ser_o         (ser_o)
);

// File: tb/tb_gated_piso_shreg.sv
module tb_gated_piso_shreg;
  localparam int CLK_PERIOD = 10;
  localparam int WIDTH      = 8;
  localparam int SYNC       = 2;

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic             inhibit_i;
  logic             shift_nload_i;
  logic             ser_i;
  logic [WIDTH-1:0] par_i;
  logic             ser_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [WIDTH-1:0] model = '0;
  int hold_edges = 0;
  bit done = 1'b0;

  gated_piso_shreg #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC)) dut (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .inhibit_i     (inhibit_i),
    .shift_nload_i (shift_nload_i),
    .ser_i         (ser_i),
    .par_i         (par_i),
    .ser_o         (ser_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: ser_o=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // R8: inhibit may only rise while the clock is high
  always @(posedge inhibit_i) begin
    n_chk++;
    if (clk_i !== 1'b1) begin
      n_bad++;
      $display("FAIL R8: clk=%b expected=1 when inhibit rose at %0t", clk_i, $time);
    end
  end

  // entered at posedge+2 (clock high); leaves at next posedge+2
  task automatic step(input logic inh, input logic sl, input logic ser,
                      input logic [WIDTH-1:0] par, input string req);
    inhibit_i = inh; shift_nload_i = sl; ser_i = ser; par_i = par;
    #1;
    check(ser_o, model[WIDTH-1], {req, " pre-edge"});
    @(posedge clk_i);
    if (hold_edges > 0) hold_edges--;
    else if (!inh) model = sl ? {model[WIDTH-2:0], ser} : par;
    #2;
    check(ser_o, model[WIDTH-1], req);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; inhibit_i = 1'b0; shift_nload_i = 1'b1; ser_i = 1'b1; par_i = '1;
    repeat (3) @(posedge clk_i);
    #2;
    check(ser_o, 1'b0, "R1 reset state");
    rst_ni = 1'b1; hold_edges = SYNC; model = '0;
  endtask

  task automatic t_release();
    step(1'b0, 1'b0, 1'b0, 8'hFF, "R2 dead edge 1");
    step(1'b0, 1'b0, 1'b0, 8'hFF, "R2 dead edge 2");
    step(1'b0, 1'b0, 1'b0, 8'hFF, "R2 first live load");
    for (int i = 0; i < WIDTH; i++) step(1'b0, 1'b1, 1'b0, 8'h00, "R2 drain");
  endtask

  task automatic t_load_shift(input logic [WIDTH-1:0] word, input logic [WIDTH-1:0] sin);
    step(1'b0, 1'b0, 1'b0, word, "R4 load");
    for (int i = 0; i < WIDTH; i++) step(1'b0, 1'b1, sin[i], ~word, "R6 R7 shift");
    for (int i = 0; i < WIDTH; i++) step(1'b0, 1'b1, 1'b0, word, "R7 serial arrival");
  endtask

  task automatic t_inhibit();
    step(1'b0, 1'b0, 1'b0, 8'hA5, "R4 load before inhibit");
    step(1'b1, 1'b1, 1'b1, 8'h00, "R3 inhibit shift");
    step(1'b1, 1'b0, 1'b0, 8'h0F, "R3 inhibit load");
    step(1'b1, 1'b1, 1'b0, 8'hFF, "R3 inhibit shift 0");
    for (int i = 0; i < WIDTH; i++) step(1'b0, 1'b1, 1'b0, 8'h00, "R3 state held");
  endtask

  task automatic t_load_ignores_ser();
    step(1'b0, 1'b0, 1'b1, 8'h00, "R5 load with ser=1");
    step(1'b0, 1'b0, 1'b1, 8'h01, "R5 load again ser=1");
    for (int i = 0; i < WIDTH; i++) step(1'b0, 1'b1, 1'b0, 8'h00, "R5 ser_i ignored");
  endtask

  task automatic t_clear_mid();
    step(1'b0, 1'b0, 1'b0, 8'hFF, "R4 load before clear");
    step(1'b0, 1'b1, 1'b1, 8'h00, "R6 shift before clear");
    step(1'b0, 1'b1, 1'b1, 8'h00, "R6 shift before clear");
    rst_ni = 1'b0;
    #1;
    check(ser_o, 1'b0, "R1 clear mid-shift");
    model = '0;
    @(posedge clk_i);
    #2;
    check(ser_o, 1'b0, "R1 clear overrides clock");
    rst_ni = 1'b1; hold_edges = SYNC;
    step(1'b0, 1'b1, 1'b1, 8'hFF, "R2 dead after clear");
    step(1'b0, 1'b0, 1'b1, 8'hFF, "R2 dead after clear");
    for (int i = 0; i < WIDTH; i++) step(1'b0, 1'b1, 1'b1, 8'h00, "R6 after clear");
  endtask

  task automatic t_back_to_back();
    step(1'b0, 1'b0, 1'b0, 8'h80, "R4 back-to-back 1");
    step(1'b0, 1'b0, 1'b0, 8'h7F, "R4 back-to-back 2");
    step(1'b0, 1'b0, 1'b1, 8'hC3, "R4 back-to-back 3");
    for (int i = 0; i < WIDTH; i++) step(1'b0, 1'b1, 1'b0, 8'h00, "R4 R7 last load wins");
  endtask

  initial begin
    t_reset();
    t_release();
    t_load_shift(8'hA5, 8'h5A);
    t_load_shift(8'h3C, 8'hF0);
    t_inhibit();
    t_load_ignores_ser();
    t_clear_mid();
    t_back_to_back();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule